// File: doc/BRIEF.md
# Mode-Dependent Activity Watchdog

This block watches two signs of life, an incoming serial-bus clock line and a single-cycle tick from an on-chip oscillator, and flags a fault when the activity it watches goes quiet for too long. Each source has its own idle counter. The counter restarts on every sign of activity and stops at `TIMEOUT_CYCLES`. Once a counter that is being watched reaches that limit, the block raises a timeout flag. The flag stays high until reset. On the first cycle of the flag, the block emits a one-cycle pulse that downstream logic can use to return its ports to a safe state.

The sources being watched depend on the operating mode. When a host manages the chip, both the bus clock and the oscillator must keep showing activity. In autonomous operation no host is present, so only the oscillator is watched and the bus line is ignored. A strap input turns the whole function off: while it is high, the flag is cleared and cannot be set.

The bus clock is asynchronous to the system clock and passes through a synchroniser chain before edge detection. The oscillator tick and the other inputs are taken to be synchronous to the system clock. The strap relies on an external pull-down so that an unconnected pin reads low, which leaves the watchdog enabled.

Top module: `activity_watchdog`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `timeout_o` and `port_reset_o` are 0.
- R2: While `wd_disable_i` is 1, `timeout_o` is 0 from the next cycle on and cannot be set. Both idle counts are held at zero, so a full window starts when the strap is released.
- R3: With `host_mode_i` = 1 (host-managed), a bus-clock idle count reaching `TIMEOUT_CYCLES` sets `timeout_o`.
- R4: With `host_mode_i` = 0 (autonomous), the bus clock has no effect on `timeout_o`, and its idle count is held at zero.
- R5: In either mode, an oscillator idle count reaching `TIMEOUT_CYCLES` sets `timeout_o`. The flag rises at the clock edge that follows the count reaching the limit.
- R6: Once `timeout_o` is 1, it stays 1 until reset or until `wd_disable_i` goes high, even after activity resumes.
- R7: `port_reset_o` is 1 for exactly one cycle: the first cycle in which `timeout_o` is 1 after being 0.
- R8: `bus_clk_i` passes through a two-flop synchroniser. Both rising and falling transitions of the synchronised line count as activity.
- R9: When the mode changes from autonomous to host-managed, the bus idle window starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_clk_i | input | 1 | Raw serial-bus clock line (asynchronous) |
| osc_tick_i | input | 1 | Single-cycle oscillator activity tick |
| host_mode_i | input | 1 | 1 = host-managed (watch both sources), 0 = autonomous (oscillator only) |
| wd_disable_i | input | 1 | 1 = watchdog off; low when left unconnected |
| timeout_o | output | 1 | Sticky timeout flag |
| port_reset_o | output | 1 | One-cycle pulse when the flag first rises |

## Verification
The bench runs several stimulus patterns and compares the outputs with a behavioural model on every cycle:
- A silent bus with a ticking oscillator in autonomous mode shows that the mode really drops the bus from the check.
- The same silent bus in host mode must trip, which separates the two modes.
- A bus that toggles only every eight cycles keeps the watchdog quiet only if both edge directions count.
- Stopping the oscillator, asserting the strap, restoring activity after a trip, and switching the mode after a long quiet bus period check stop-the-oscillator, disable, stickiness and window-restart behaviour respectively.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic {
      WDG_AUTO = 1'b0,
      WDG_HOST = 1'b1
   } wdg_mode_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/wdg_sync_edge.sv
module wdg_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   output logic edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wdg_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= 1'b0;
            else         chain_q[i] <= din_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= 1'b0;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign edge_o = chain_q[STAGES-1] ^ chain_q[STAGES];

   // R8: an edge report means the synchronised level just moved
   p_edge_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o |=> (chain_q[STAGES] != $past(chain_q[STAGES])));

endmodule

// File: rtl/wdg_idle_counter.sv
module wdg_idle_counter #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned W     = wdg_pkg::cnt_width(LIMIT)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   output logic [W-1:0] count_o,
   output logic         expired_o
);

   localparam logic [W-1:0] LimitVal = W'(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("wdg_idle_counter: LIMIT must be at least 2");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (clear_i)         cnt_q <= '0;
      else if (cnt_q != LimitVal) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o   = cnt_q;
   assign expired_o = (cnt_q == LimitVal);

   // R5: count saturates and never passes the limit
   p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LimitVal);

   // R5: activity restarts the window
   p_clear_restarts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
   parameter int unsigned TIMEOUT_CYCLES = 16,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bus_clk_i,
   input  logic osc_tick_i,
   input  logic host_mode_i,
   input  logic wd_disable_i,
   output logic timeout_o,
   output logic port_reset_o
);
   import wdg_pkg::*;

   localparam int unsigned CntW = cnt_width(TIMEOUT_CYCLES);

   if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
      $error("activity_watchdog: TIMEOUT_CYCLES must be at least 2");
   end

   wdg_mode_e    mode;
   logic         bus_edge;
   logic         osc_clr, bus_clr;
   logic         osc_exp, bus_exp;
   logic [CntW-1:0] osc_cnt, bus_cnt;
   logic         trip;
   logic         flag_q, flag_d1_q;

   assign mode = wdg_mode_e'(host_mode_i);

   wdg_sync_edge #(.STAGES(SYNC_STAGES)) u_bus_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (bus_clk_i),
      .edge_o (bus_edge)
   );

   assign osc_clr = wd_disable_i | osc_tick_i;
   assign bus_clr = wd_disable_i | (mode == WDG_AUTO) | bus_edge;

   wdg_idle_counter #(.LIMIT(TIMEOUT_CYCLES), .W(CntW)) u_osc_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (osc_clr),
      .count_o   (osc_cnt),
      .expired_o (osc_exp)
   );

   wdg_idle_counter #(.LIMIT(TIMEOUT_CYCLES), .W(CntW)) u_bus_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (bus_clr),
      .count_o   (bus_cnt),
      .expired_o (bus_exp)
   );

   assign trip = osc_exp | ((mode == WDG_HOST) & bus_exp);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q    <= 1'b0;
         flag_d1_q <= 1'b0;
      end else begin
         flag_d1_q <= flag_q;
         if (wd_disable_i) flag_q <= 1'b0;
         else if (trip)    flag_q <= 1'b1;
      end
   end

   assign timeout_o    = flag_q;
   assign port_reset_o = flag_q & ~flag_d1_q;

   // R2: strap high forces the flag low on the next cycle
   p_disable_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_disable_i |=> !timeout_o);

   // R4: autonomous mode keeps the bus window parked at zero
   p_auto_bus_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == WDG_AUTO) |=> (bus_cnt == '0));

   // R6: flag holds while enabled
   p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timeout_o && !wd_disable_i) |=> timeout_o);

   // R7: pulse lasts one cycle
   p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_reset_o |=> !port_reset_o);

   // R7: pulse only on the first flag cycle
   p_pulse_on_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_reset_o |-> $rose(timeout_o));

   // R5: oscillator window at its limit with strap low trips the flag
   p_osc_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (osc_exp && !wd_disable_i) |=> timeout_o);

endmodule

// File: tb/activity_watchdog_tb.sv
module activity_watchdog_tb;

   localparam int unsigned T = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_raw = 1'b0;
   logic osc_tick = 1'b0;
   logic host_mode = 1'b0;
   logic wd_dis = 1'b0;
   logic timeout, preset;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int osc_period = 0;
   int bus_half = 0;
   int pulse_count = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   activity_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bus_clk_i    (bus_raw),
      .osc_tick_i   (osc_tick),
      .host_mode_i  (host_mode),
      .wd_disable_i (wd_dis),
      .timeout_o    (timeout),
      .port_reset_o (preset)
   );

   // stimulus generators, driven away from the active edge
   int oc = 0;
   int bc = 0;
   always @(negedge clk) begin
      if (osc_period == 0) osc_tick <= 1'b0;
      else begin
         oc = oc + 1;
         osc_tick <= (oc % osc_period == 0);
      end
      if (bus_half != 0) begin
         bc = bc + 1;
         if (bc % bus_half == 0) bus_raw <= ~bus_raw;
      end
   end

   // behavioural reference model
   bit bq[$];
   int m_osc_idle, m_bus_idle;
   bit m_flag, m_pulse;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bq = '{0, 0, 0};
         m_osc_idle = 0; m_bus_idle = 0; m_flag = 0; m_pulse = 0;
      end else begin
         bit act, cond, old_flag;
         act = (bq[1] != bq[2]);
         cond = (m_osc_idle == T) || (host_mode && m_bus_idle == T);
         old_flag = m_flag;
         if (wd_dis || osc_tick) m_osc_idle = 0;
         else if (m_osc_idle < T) m_osc_idle = m_osc_idle + 1;
         if (wd_dis || !host_mode || act) m_bus_idle = 0;
         else if (m_bus_idle < T) m_bus_idle = m_bus_idle + 1;
         if (wd_dis) m_flag = 0;
         else if (cond) m_flag = 1;
         m_pulse = m_flag && !old_flag;
         bq.push_front(bus_raw);
         void'(bq.pop_back());
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the model (R3 R4 R5 R7 R8 R9 timing)
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         check("R5 model timeout", timeout, m_flag);
         check("R7 model pulse", preset, m_pulse);
         if (preset === 1'b1) pulse_count++;
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      run(3);
      check("R1 reset timeout", timeout, 1'b0);
      check("R1 reset pulse", preset, 1'b0);
      rst_n = 1'b1;
      run(1);
      check("R1 after release", timeout, 1'b0);

      // autonomous, silent bus, oscillator alive
      osc_period = 4;
      run(40);
      check("R4 bus ignored in auto", timeout, 1'b0);

      // host mode, bus still silent
      host_mode = 1'b1;
      pulse_count = 0;
      run(30);
      check("R3 bus idle trips in host", timeout, 1'b1);
      checks++;
      if (pulse_count != 1) begin
         errors++;
         $display("FAIL R7 pulse count: actual=%0d expected=1", pulse_count);
      end

      // activity resumes, flag stays
      bus_half = 3;
      run(20);
      check("R6 sticky after activity", timeout, 1'b1);

      // strap clears and blocks
      wd_dis = 1'b1;
      run(2);
      check("R2 strap clears flag", timeout, 1'b0);
      osc_period = 0; bus_half = 0;
      run(40);
      check("R2 strap blocks timeout", timeout, 1'b0);

      // slow bus toggle: every edge direction must count
      osc_period = 4; bus_half = 8;
      wd_dis = 1'b0;
      run(60);
      check("R8 both edge directions count", timeout, 1'b0);

      // oscillator stops in host mode
      osc_period = 0;
      run(30);
      check("R5 oscillator stop trips", timeout, 1'b1);

      // re-arm through reset, then test window restart on mode change
      rst_n = 1'b0;
      run(2);
      osc_period = 4; bus_half = 0; host_mode = 1'b0;
      rst_n = 1'b1;
      run(40);
      check("R4 auto quiet bus", timeout, 1'b0);
      host_mode = 1'b1;
      run(8);
      check("R9 window restarts on mode change", timeout, 1'b0);
      run(12);
      check("R9 host window expires later", timeout, 1'b1);

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

endmodule